// File: doc/BRIEF.md
# Two-Color LED Matrix Row-Scan Controller

This block refreshes a chain of two-color dot-matrix LED panels. Each panel has 16 rows and 32 columns, and only one row is lit at a time. For every row the controller reads the red and green pixel bits from a synchronous frame-buffer read port, one pixel per read. It sends them out on two serial data lines with a common shift clock. Once all bits for the whole chain are out, it blanks the display, pulses the latch, moves the 4-bit row address to the row just loaded and lights the display again after a set blanking time. The number of panels in the chain is the parameter `N_UNITS`. The chain is `COLS = 32*N_UNITS` columns wide.

The frame buffer holds one bit per color at address `row*COLS + col`, with read latency one cycle. Column `COLS-1` belongs to the panel farthest down the chain, and it is shifted first. A row-period timer pads every row to `ROW_CYC` system cycles, so every row is lit for the same time. The shift clock comes from the system clock: it is high for `HALF_DIV` cycles and low for `HALF_DIV+1` cycles. Data only changes while the shift clock is low.

The sequencer is a state machine with these states:
- ST_IDLE is the single cycle after reset. It goes to ST_FETCH.
- ST_FETCH issues one frame-buffer read and goes to ST_LOW.
- ST_LOW holds the shift clock low for `HALF_DIV` cycles and goes to ST_HIGH.
- ST_HIGH holds the shift clock high for `HALF_DIV` cycles. It goes back to ST_FETCH, or to ST_BLANK after the last bit of the row.
- ST_BLANK raises the blank output for one cycle and goes to ST_LATCH.
- ST_LATCH holds the latch high for `HALF_DIV` cycles and goes to ST_ADDR.
- ST_ADDR loads the row address and goes to ST_HOLD.
- ST_HOLD keeps the display blanked for `BLANK_CYC` cycles and goes to ST_PAD.
- ST_PAD lights the display and waits for the row timer, then goes to ST_FETCH.

Top module: `ledscan_ctrl`

## Requirements
- R1: While reset is high and on leaving it: `blank`=1 (display dark), `latch`=0, `sclk`=0, `fb_rd_en`=0 and `row_addr`=0. The first row shifted and latched after reset is row 0.
- R2: Between two latch pulses exactly `COLS` rising edges of `sclk` occur. Each high phase lasts `HALF_DIV` cycles, and rising edges within a row are `2*HALF_DIV+1` cycles apart.
- R3: At the k-th rising edge of a row (k from 0), `rdat` equals the red bit and `gdat` equals the green bit at frame-buffer address `r*COLS + (COLS-1-k)`, where r is the row being loaded. The value 1 means the dot is on. Read data is valid one cycle after `fb_rd_en`.
- R4: `rdat` and `gdat` never change while `sclk` is high.
- R5: `blank` is already high in the cycle before `latch` rises. `latch` is high only while `blank` is high and `sclk` is low, and each latch pulse lasts `HALF_DIV` cycles.
- R6: `row_addr` changes only while `blank`=1 and `latch`=0. It changes in the cycle after `latch` falls.
- R7: `blank` stays high for exactly `BLANK_CYC` cycles, counted from the cycle in which the new row address appears, and then drops to 0.
- R8: Latched rows follow 0, 1, …, 15 and then wrap to 0. Each row address steps by one modulo 16.
- R9: Consecutive latch rising edges are exactly `ROW_CYC` cycles apart whenever `ROW_CYC` is at least `COLS*(2*HALF_DIV+1)+HALF_DIV+BLANK_CYC+3`.
- R10: `fb_rd_en` pulses exactly `COLS` times per row, one cycle each, only while `sclk` and `latch` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fb_addr | output | clog2(16*COLS) | Frame-buffer read address, row*COLS+col |
| fb_rd_en | output | 1 | Frame-buffer read strobe |
| fb_red | input | 1 | Red pixel bit, valid one cycle after the strobe |
| fb_grn | input | 1 | Green pixel bit, valid one cycle after the strobe |
| sclk | output | 1 | Shift clock to the panels (data taken on rising edge) |
| rdat | output | 1 | Red serial data, 1 = dot on |
| gdat | output | 1 | Green serial data, 1 = dot on |
| latch | output | 1 | High copies shift registers to column drivers |
| blank | output | 1 | High turns all LEDs off |
| row_addr | output | 4 | Binary address of the lit row |

## Verification
The state machine can go wrong in three main ways:
- A stuck or skipped state shows up at the next latch. The bench sees a wrong bit count, a wrong row period or a wrong next row address at that point, so the error is seen within one row period.
- A wrong column order or an off-by-one in the read timing makes the shifted bits differ from the frame-buffer model on the first row that holds mixed data.
- Mis-ordered blank, latch and address steps break a port relation, such as a latch pulse without blank or an address change while lit. The assertions catch this in the same cycle.

// File: rtl/ledscan_pkg.sv
`timescale 1ns/1ps
package ledscan_pkg;

    // Fixed geometry of one panel in the chain
    localparam int UNIT_COLS  = 32;
    localparam int PANEL_ROWS = 16;
    localparam int ROW_AW     = 4;

    // Per-row sequencing states
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOW,
        ST_HIGH,
        ST_BLANK,
        ST_LATCH,
        ST_ADDR,
        ST_HOLD,
        ST_PAD
    } scan_state_t;

endpackage

// File: rtl/ledscan_downcnt.sv
`timescale 1ns/1ps
// Loadable down-counter used to time clock phases, latch width and blanking.
module ledscan_downcnt #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/ledscan_rowtimer.sv
`timescale 1ns/1ps
// Counts cycles since the start of a row; flags when the row period is used up.
module ledscan_rowtimer #(
    parameter int PERIOD = 1400
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic expired
);

    localparam int CW = $clog2(PERIOD + 1);
    localparam logic [CW-1:0] LIMIT = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    assign expired = (cnt_q >= LIMIT);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ledscan_colseq.sv
`timescale 1ns/1ps
// Tracks the bit position inside a row and the row being loaded,
// and forms the frame-buffer address (far end of the chain first).
module ledscan_colseq #(
    parameter int COLS = 64,
    parameter int ROWS = 16,
    parameter int RW   = 4,
    parameter int AW   = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_adv,
    input  logic          row_adv,
    output logic          last_bit,
    output logic [RW-1:0] shift_row,
    output logic [AW-1:0] fb_addr
);

    localparam int CW = $clog2(COLS);
    localparam logic [CW-1:0] LAST_BIT = CW'(COLS - 1);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
    localparam bit POW2 = ((COLS & (COLS - 1)) == 0);

    logic [CW-1:0] bit_q;
    logic [CW-1:0] col;
    logic [RW-1:0] row_q;

    assign last_bit  = (bit_q == LAST_BIT);
    assign col       = LAST_BIT - bit_q;
    assign shift_row = row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q <= '0;
        end else if (bit_adv) begin
            bit_q <= last_bit ? '0 : bit_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
        end else if (row_adv) begin
            row_q <= (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
        end
    end

    generate
        if (POW2) begin : g_cat
            assign fb_addr = AW'({row_q, col});
        end else begin : g_mul
            assign fb_addr = AW'(row_q) * AW'(COLS) + AW'(col);
        end
    endgenerate

endmodule

// File: rtl/ledscan_ctrl.sv
`timescale 1ns/1ps
module ledscan_ctrl
    import ledscan_pkg::*;
#(
    parameter int N_UNITS   = 2,
    parameter int HALF_DIV  = 10,
    parameter int BLANK_CYC = 8,
    parameter int ROW_CYC   = 1400,
    localparam int COLS     = UNIT_COLS * N_UNITS,
    localparam int FB_AW    = $clog2(COLS * PANEL_ROWS)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [FB_AW-1:0]  fb_addr,
    output logic              fb_rd_en,
    input  logic              fb_red,
    input  logic              fb_grn,
    output logic              sclk,
    output logic              rdat,
    output logic              gdat,
    output logic              latch,
    output logic              blank,
    output logic [ROW_AW-1:0] row_addr
);

    localparam int TMAX = (HALF_DIV > BLANK_CYC) ? HALF_DIV : BLANK_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] PHASE_LD = TW'(HALF_DIV - 1);
    localparam logic [TW-1:0] HOLD_LD  = TW'(BLANK_CYC - 1);

    scan_state_t       state_q, state_d;
    logic              tmr_load, tmr_zero;
    logic [TW-1:0]     tmr_val;
    logic              bit_adv, row_adv, last_bit;
    logic [ROW_AW-1:0] shift_row;
    logic              row_restart, row_expired;
    logic              lit_q, lit_d;
    logic              rd_q1;

    // ---------------- datapath helpers ----------------
    ledscan_downcnt #(.TW(TW)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    ledscan_rowtimer #(.PERIOD(ROW_CYC)) u_rowtmr (
        .clk     (clk),
        .rst     (rst),
        .restart (row_restart),
        .expired (row_expired)
    );

    ledscan_colseq #(
        .COLS (COLS),
        .ROWS (PANEL_ROWS),
        .RW   (ROW_AW),
        .AW   (FB_AW)
    ) u_colseq (
        .clk       (clk),
        .rst       (rst),
        .bit_adv   (bit_adv),
        .row_adv   (row_adv),
        .last_bit  (last_bit),
        .shift_row (shift_row),
        .fb_addr   (fb_addr)
    );

    assign bit_adv     = (state_q == ST_HIGH) && tmr_zero;
    assign row_adv     = (state_q == ST_ADDR);
    assign row_restart = (state_q == ST_IDLE) || ((state_q == ST_PAD) && row_expired);

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ST_FETCH;
            ST_FETCH: state_d = ST_LOW;
            ST_LOW:   if (tmr_zero) state_d = ST_HIGH;
            ST_HIGH:  if (tmr_zero) state_d = last_bit ? ST_BLANK : ST_FETCH;
            ST_BLANK: state_d = ST_LATCH;
            ST_LATCH: if (tmr_zero) state_d = ST_ADDR;
            ST_ADDR:  state_d = ST_HOLD;
            ST_HOLD:  if (tmr_zero) state_d = ST_PAD;
            ST_PAD:   if (row_expired) state_d = ST_FETCH;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Phase timer is loaded on entry to each timed state
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (state_d != state_q) begin
            unique case (state_d)
                ST_LOW, ST_HIGH, ST_LATCH: begin
                    tmr_load = 1'b1;
                    tmr_val  = PHASE_LD;
                end
                ST_HOLD: begin
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_LD;
                end
                default: begin
                    tmr_load = 1'b0;
                    tmr_val  = '0;
                end
            endcase
        end
    end

    // Display becomes lit for good once the first row has been loaded
    assign lit_d = lit_q || (state_d == ST_PAD);

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk     <= 1'b0;
            latch    <= 1'b0;
            blank    <= 1'b1;
            fb_rd_en <= 1'b0;
            rd_q1    <= 1'b0;
            rdat     <= 1'b0;
            gdat     <= 1'b0;
            row_addr <= '0;
            lit_q    <= 1'b0;
        end else begin
            lit_q    <= lit_d;
            sclk     <= (state_d == ST_HIGH);
            latch    <= (state_d == ST_LATCH);
            fb_rd_en <= (state_d == ST_FETCH);
            blank    <= !(lit_d && (state_d inside {ST_FETCH, ST_LOW, ST_HIGH, ST_PAD}));
            rd_q1    <= fb_rd_en;
            if (rd_q1) begin
                rdat <= fb_red;
                gdat <= fb_grn;
            end
            if (state_q == ST_ADDR) begin
                row_addr <= shift_row;
            end
        end
    end

endmodule

// File: rtl/ledscan_ctrl_chk.sv
`timescale 1ns/1ps
module ledscan_ctrl_chk
    import ledscan_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fb_rd_en,
    input logic              sclk,
    input logic              rdat,
    input logic              gdat,
    input logic              latch,
    input logic              blank,
    input logic [ROW_AW-1:0] row_addr
);

    // R4: serial data is frozen while the shift clock is high
    a_r4_data_held_high: assert property (@(posedge clk) disable iff (rst)
        sclk |-> ($stable(rdat) && $stable(gdat)));

    // R5: latch only while dark and with the shift clock low
    a_r5_latch_blanked: assert property (@(posedge clk) disable iff (rst)
        latch |-> (blank && !sclk));

    // R5: blank is already high the cycle before latch rises
    a_r5_blank_first: assert property (@(posedge clk) disable iff (rst)
        $rose(latch) |-> $past(blank));

    // R6: row address moves only while dark and with latch low
    a_r6_row_move_dark: assert property (@(posedge clk) disable iff (rst)
        (row_addr != $past(row_addr)) |-> (blank && !latch));

    // R8: row address only ever steps by one (mod 16)
    a_r8_row_step: assert property (@(posedge clk) disable iff (rst)
        (row_addr != $past(row_addr)) |-> (row_addr == $past(row_addr) + 4'd1));

    // R10: reads happen only in the low phase, outside the latch pulse
    a_r10_read_in_low: assert property (@(posedge clk) disable iff (rst)
        fb_rd_en |-> (!sclk && !latch));

    // R10: each read strobe is a single cycle
    a_r10_read_single: assert property (@(posedge clk) disable iff (rst)
        fb_rd_en |=> !fb_rd_en);

endmodule

bind ledscan_ctrl ledscan_ctrl_chk u_chk (.*);

// File: tb/sim_ledscan_ctrl.sv
`timescale 1ns/1ps
module sim_ledscan_ctrl;

    localparam int NU  = 2;
    localparam int H   = 10;
    localparam int BL  = 8;
    localparam int RC  = 1400;
    localparam int W   = 32 * NU;
    localparam int NW  = 16 * W;
    localparam int AW  = $clog2(NW);

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] fb_addr;
    logic          fb_rd_en;
    logic          fb_red = 1'b0;
    logic          fb_grn = 1'b0;
    logic          sclk, rdat, gdat, latch, blank;
    logic [3:0]    row_addr;

    always #2.5 clk = ~clk;

    ledscan_ctrl #(
        .N_UNITS (NU),
        .HALF_DIV(H),
        .BLANK_CYC(BL),
        .ROW_CYC (RC)
    ) u0 (
        .clk(clk), .rst(rst), .fb_addr(fb_addr), .fb_rd_en(fb_rd_en),
        .fb_red(fb_red), .fb_grn(fb_grn), .sclk(sclk), .rdat(rdat),
        .gdat(gdat), .latch(latch), .blank(blank), .row_addr(row_addr)
    );

    // ---------------- frame-buffer model ----------------
    logic mem_r [NW];
    logic mem_g [NW];

    always @(posedge clk) begin
        if (fb_rd_en) begin
            fb_red <= mem_r[fb_addr];
            fb_grn <= mem_g[fb_addr];
        end
    end

    task automatic fill(input int p);
        for (int i = 0; i < NW; i++) begin
            case (p % 4)
                1: begin mem_r[i] = 1'b1; mem_g[i] = 1'b0; end
                2: begin
                    mem_r[i] = 1'((i % 2) ^ ((i / W) % 2));
                    mem_g[i] = ~mem_r[i];
                end
                3: begin
                    mem_r[i] = ($urandom_range(0, 3) == 0);
                    mem_g[i] = ($urandom_range(0, 3) == 0);
                end
                default: begin
                    mem_r[i] = 1'($urandom_range(0, 1));
                    mem_g[i] = 1'($urandom_range(0, 1));
                end
            endcase
        end
    endtask

    function automatic logic exp_bit(input int row, input int k, input bit grn);
        int a;
        a = row * W + (W - 1 - k);
        return grn ? mem_g[a] : mem_r[a];
    endfunction

    // ---------------- check bookkeeping ----------------
    int n_chk = 0;
    int n_bad = 0;
    int frames = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- port monitor ----------------
    int   cyc, k, rd_cnt, last_rise, hi_start, lat_start, last_lat, bl_cnt, exp_row;
    bit   have_rise, have_lat, pend, counting, tim_bad, stab_bad, ord_bad, fresh;
    logic sclk_p, latch_p, blank_p, rdat_p, gdat_p;
    logic [3:0] row_p;
    logic cap_r [W];
    logic cap_g [W];

    always @(negedge clk) begin
        if (rst) begin
            cyc = 0; k = 0; rd_cnt = 0; exp_row = 0; bl_cnt = 0;
            have_rise = 0; have_lat = 0; pend = 0; counting = 0;
            tim_bad = 0; stab_bad = 0; ord_bad = 0; fresh = 1;
        end else begin
            cyc++;
            if (fb_rd_en) rd_cnt++;
            if (sclk && sclk_p && (rdat != rdat_p || gdat != gdat_p)) stab_bad = 1;
            if (row_addr != row_p && (!blank || latch)) ord_bad = 1;
            if (sclk && !sclk_p) begin
                if (k < W) begin cap_r[k] = rdat; cap_g[k] = gdat; end
                if (have_rise && k > 0 && (cyc - last_rise) != 2 * H + 1) tim_bad = 1;
                last_rise = cyc; have_rise = 1; hi_start = cyc; k++;
            end
            if (!sclk && sclk_p && (cyc - hi_start) != H) tim_bad = 1;

            if (pend) begin
                chk(row_addr == 4'(exp_row), fresh ? "R1" : "R8", "row address after latch",
                    int'(row_addr), exp_row);
                pend = 0; counting = 1; bl_cnt = 0; fresh = 0;
            end
            if (counting) begin
                if (blank) bl_cnt++;
                else begin
                    chk(bl_cnt == BL, "R7", "blank cycles after row change", bl_cnt, BL);
                    counting = 0;
                    if (exp_row == 15) begin frames++; fill(frames); end
                    exp_row = (exp_row + 1) % 16;
                end
            end

            if (latch && !latch_p) begin
                int errs, first_k;
                errs = 0; first_k = -1;
                for (int j = 0; j < W; j++) begin
                    if (cap_r[j] !== exp_bit(exp_row, j, 0) || cap_g[j] !== exp_bit(exp_row, j, 1)) begin
                        errs++;
                        if (first_k < 0) first_k = j;
                    end
                end
                chk(errs == 0, fresh ? "R1" : "R3", "mismatched bits in row", errs, 0);
                chk(k == W, "R2", "shift edges per row", k, W);
                chk(!tim_bad, "R2", "shift clock timing errors", int'(tim_bad), 0);
                chk(!stab_bad, "R4", "data change while sclk high", int'(stab_bad), 0);
                chk(blank && blank_p, "R5", "blank before latch", int'(blank_p), 1);
                chk(rd_cnt == W, "R10", "reads per row", rd_cnt, W);
                chk(!ord_bad, "R6", "row change while lit or latching", int'(ord_bad), 0);
                if (have_lat) chk((cyc - last_lat) == RC, "R9", "row period", cyc - last_lat, RC);
                last_lat = cyc; have_lat = 1; lat_start = cyc;
                k = 0; rd_cnt = 0; tim_bad = 0; stab_bad = 0; ord_bad = 0; have_rise = 0;
            end
            if (!latch && latch_p) begin
                chk((cyc - lat_start) == H, "R5", "latch width", cyc - lat_start, H);
                chk(row_addr == row_p, "R6", "row held in latch-fall cycle",
                    int'(row_addr), int'(row_p));
                pend = 1;
            end
        end
        sclk_p = sclk; latch_p = latch; blank_p = blank;
        rdat_p = rdat; gdat_p = gdat; row_p = row_addr;
    end

    task automatic check_reset_state;
        chk(blank == 1'b1, "R1", "blank in reset", int'(blank), 1);
        chk(latch == 1'b0, "R1", "latch in reset", int'(latch), 0);
        chk(sclk == 1'b0, "R1", "sclk in reset", int'(sclk), 0);
        chk(fb_rd_en == 1'b0, "R1", "read strobe in reset", int'(fb_rd_en), 0);
        chk(row_addr == 4'd0, "R1", "row address in reset", int'(row_addr), 0);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        int seed_v;
        seed_v = $urandom(32'h1d5e);
        fill(0);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        wait (frames >= 2);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        wait (frames >= 4);
        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual frames %0d expected 4", frames);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule